// File: doc/BRIEF.md
# Low-Storage Guard and Prefix Relocator

This unit sits between a source of real addresses and physical memory. For every request it decides whether a store lands in one of two protected 512-byte windows at the bottom of storage, and it relocates the real address to an absolute address. Relocation exchanges the lowest 8 KB of storage with an 8 KB area whose base is held in a programmable prefix register. Either block is reached through the other's address. Every other address passes through unchanged.

Protection is switched on by a global enable. When dynamic translation is on, it is also gated by a private-space bit. The address-space mode picks which of three private bits applies. An unsupported mode raises an error and blocks the access. A request presented with `reqValid` gives a registered response one clock later. The response carries the absolute address, a protection-fault indication and a hint that write permission for the page must not be cached.

Top module: `low_guard_relocator`

## Requirements
- R1: After reset, all response outputs and `prefixAlignErr` are 0, and the prefix register holds 0, so addresses map to themselves.
- R2: A request sampled at a clock edge with `reqValid`=1 produces `rspValid`=1 for exactly the following cycle, with exactly one of `rspOk`, `rspProtFault` and `rspModeErr` set. With `rspValid`=0, all response flags are 0.
- R3: When protection is active, a store (`reqIsStore`=1) whose exact address lies in bytes 0..511 or 4096..4607 sets `rspProtFault`=1 and `rspOk`=0, and drives `rspAbsAddr`=0. Stores to other addresses and all loads do not fault.
- R4: When protection is active, any request whose page-aligned address is 0 or 4096 (that is, any address below 8192) sets `rspWriteInvHint`=1, whether or not it faults. Other addresses leave the hint at 0.
- R5: With `protEnable`=0, no request faults or raises the hint.
- R6: With `xlateOn`=1, `spaceMode` selects the private bit: 0 selects `privPrimary`, 1 selects `privSecondary` and 2 selects `privHome`. If the selected bit is 1, protection is inactive. With `xlateOn`=0, the private bits have no effect.
- R7: With `xlateOn`=1 and `spaceMode`=3, the response has `rspModeErr`=1, `rspOk`=0, no fault, no hint and `rspAbsAddr`=0. With `xlateOn`=0, `spaceMode`=3 has no effect.
- R8: A granted address below 0x2000 maps to that address plus the prefix.
- R9: A granted address in [prefix, prefix+0x2000) maps to that address minus the prefix. Any other granted address is returned unchanged. The low-block rule takes precedence when the prefix is 0.
- R10: A prefix write (`prefixWrEn`=1) whose low 13 bits are all 0 loads the prefix at that clock edge. Any other prefix write is ignored, and `prefixAlignErr` is 1 for the single following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| prefixWrEn | input | 1 | Prefix load strobe |
| prefixWrData | input | 64 | New prefix value |
| reqValid | input | 1 | Request present |
| reqAddr | input | 64 | Real address of the request |
| reqIsStore | input | 1 | 1 = store, 0 = load or fetch |
| protEnable | input | 1 | Global low-storage protection enable |
| xlateOn | input | 1 | Dynamic translation active |
| spaceMode | input | 2 | 0 primary, 1 secondary, 2 home, 3 unsupported |
| privPrimary | input | 1 | Private-space bit of the primary space |
| privSecondary | input | 1 | Private-space bit of the secondary space |
| privHome | input | 1 | Private-space bit of the home space |
| rspValid | output | 1 | Response present |
| rspAbsAddr | output | 64 | Absolute address (0 when blocked) |
| rspOk | output | 1 | Access granted |
| rspProtFault | output | 1 | Protection fault |
| rspWriteInvHint | output | 1 | Do not cache write permission for this page |
| rspModeErr | output | 1 | Unsupported address-space mode |
| prefixAlignErr | output | 1 | Last prefix write was unaligned and ignored |

## Verification
The protection check is exercised with stores and loads at both edges of each window, at 511/512, 4095/4096 and 4607/4608. This separates an exact-address check from a page-granular one, and a store check from a load check. The hint is probed at addresses that lie in a protected page but outside a window, which separates the hint condition from the fault condition. Every private bit is set on its own under each mode and with translation off, which exposes a wrong selection or a missing translation gate. Relocation uses a nonzero prefix with addresses in the low block, in the prefix block, just past each of them and far away. A zero-prefix case checks precedence, and an unaligned write checks that the prefix is left unchanged.

// File: rtl/low_guard_pkg.sv
package low_guard_pkg;

  typedef enum logic [1:0] {
    SPACE_PRIMARY   = 2'd0,
    SPACE_SECONDARY = 2'd1,
    SPACE_HOME      = 2'd2,
    SPACE_BAD       = 2'd3
  } spaceMode_e;

  // address classification produced by the datapath for the control
  typedef struct packed {
    logic pageInWin;
    logic exactInWin;
    logic prefixAligned;
  } addrFlags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic grant;
    logic fault;
    logic hint;
    logic modeErr;
    logic loadPrefix;
  } ctrlStrobes_t;

endpackage

// File: rtl/low_guard_ctrl.sv
module low_guard_ctrl
  import low_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqIsStore,
  input  logic         protEnable,
  input  logic         xlateOn,
  input  logic [1:0]   spaceMode,
  input  logic         privPrimary,
  input  logic         privSecondary,
  input  logic         privHome,
  input  logic         prefixWrEn,
  input  addrFlags_t   flags,
  output ctrlStrobes_t strobes,
  output logic         prefixAlignErr
);

  spaceMode_e modeSel;
  logic privSel;
  logic badMode;
  logic protActive;

  always_comb begin
    modeSel = spaceMode_e'(spaceMode);
    unique case (modeSel)
      SPACE_PRIMARY:   privSel = privPrimary;
      SPACE_SECONDARY: privSel = privSecondary;
      SPACE_HOME:      privSel = privHome;
      default:         privSel = 1'b0;
    endcase
    badMode    = xlateOn && (modeSel == SPACE_BAD);
    protActive = protEnable && !(xlateOn && privSel) && !badMode;
  end

  always_comb begin
    strobes.capture    = reqValid;
    strobes.modeErr    = reqValid && badMode;
    strobes.fault      = reqValid && protActive && reqIsStore && flags.exactInWin;
    strobes.hint       = reqValid && protActive && flags.pageInWin;
    strobes.grant      = reqValid && !badMode && !strobes.fault;
    strobes.loadPrefix = prefixWrEn && flags.prefixAligned;
  end

  always_ff @(posedge clk) begin
    if (!rstN) prefixAlignErr <= 1'b0;
    else       prefixAlignErr <= prefixWrEn && !flags.prefixAligned;
  end

  // R10: the rejection flag only follows a prefix write
  a_r10_reject_after_write: assert property (@(posedge clk) disable iff (!rstN)
    prefixAlignErr |-> $past(prefixWrEn));

  // R5: a disabled guard never produces a fault strobe
  a_r5_no_fault_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !protEnable |-> !strobes.fault && !strobes.hint);

endmodule

// File: rtl/low_guard_datapath.sv
module low_guard_datapath
  import low_guard_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12,
  parameter int WIN_BITS  = 9,
  parameter int NUM_WIN   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] prefixWrData,
  input  ctrlStrobes_t      strobes,
  output addrFlags_t        flags,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAbsAddr,
  output logic              rspOk,
  output logic              rspProtFault,
  output logic              rspWriteInvHint,
  output logic              rspModeErr
);

  localparam int SWAP_BITS  = PAGE_BITS + $clog2(NUM_WIN);
  localparam int PAGE_NUM_W = ADDR_W - PAGE_BITS;
  localparam int HI_W       = ADDR_W - SWAP_BITS;

  logic [ADDR_W-1:0]  prefixQ;
  logic [NUM_WIN-1:0] exactHit;
  logic               lowBlock;
  logic               inPrefix;
  logic [ADDR_W-1:0]  mappedAddr;

  // one comparator per protected window, one window at the start of each page
  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    assign exactHit[gi] = (reqAddr[ADDR_W-1:PAGE_BITS] == PAGE_NUM_W'(gi)) &&
                          (reqAddr[PAGE_BITS-1:WIN_BITS] == '0);
  end

  assign lowBlock = (reqAddr[ADDR_W-1:SWAP_BITS] == HI_W'(0));
  assign inPrefix = (reqAddr[ADDR_W-1:SWAP_BITS] == prefixQ[ADDR_W-1:SWAP_BITS]);

  always_comb begin
    flags.exactInWin    = |exactHit;
    flags.pageInWin     = lowBlock;
    flags.prefixAligned = (prefixWrData[SWAP_BITS-1:0] == '0);
  end

  // the prefix is aligned, so add and subtract reduce to replacing the upper bits
  always_comb begin
    if (lowBlock)
      mappedAddr = {prefixQ[ADDR_W-1:SWAP_BITS], reqAddr[SWAP_BITS-1:0]};
    else if (inPrefix)
      mappedAddr = {HI_W'(0), reqAddr[SWAP_BITS-1:0]};
    else
      mappedAddr = reqAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   prefixQ <= '0;
    else if (strobes.loadPrefix) prefixQ <= prefixWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid        <= 1'b0;
      rspAbsAddr      <= '0;
      rspOk           <= 1'b0;
      rspProtFault    <= 1'b0;
      rspWriteInvHint <= 1'b0;
      rspModeErr      <= 1'b0;
    end else begin
      rspValid        <= strobes.capture;
      rspAbsAddr      <= strobes.grant ? mappedAddr : '0;
      rspOk           <= strobes.grant;
      rspProtFault    <= strobes.fault;
      rspWriteInvHint <= strobes.hint;
      rspModeErr      <= strobes.modeErr;
    end
  end

  // R2: no flag without a response
  a_r2_flags_need_valid: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspOk || rspProtFault || rspWriteInvHint || rspModeErr));

  // R2: exactly one outcome per response
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({rspOk, rspProtFault, rspModeErr}) == 1);

  // R3: a faulting address is always inside a protected page
  a_r3_fault_has_hint: assert property (@(posedge clk) disable iff (!rstN)
    rspProtFault |-> rspWriteInvHint);

  // R3 / R7: blocked accesses return no address
  a_r3_blocked_addr_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rspProtFault || rspModeErr) |-> rspAbsAddr == '0);

  // R9: addresses outside both swapped blocks pass unchanged
  a_r9_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (rspOk && $past(reqAddr[ADDR_W-1:SWAP_BITS]) != HI_W'(0) &&
     $past(reqAddr[ADDR_W-1:SWAP_BITS]) != $past(prefixQ[ADDR_W-1:SWAP_BITS]))
    |-> rspAbsAddr == $past(reqAddr));

  // R10: the prefix only changes on an accepted load
  a_r10_prefix_stable: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.loadPrefix) |-> $stable(prefixQ));

endmodule

// File: rtl/low_guard_relocator.sv
module low_guard_relocator
  import low_guard_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12,
  parameter int WIN_BITS  = 9,
  parameter int NUM_WIN   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              prefixWrEn,
  input  logic [ADDR_W-1:0] prefixWrData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsStore,
  input  logic              protEnable,
  input  logic              xlateOn,
  input  logic [1:0]        spaceMode,
  input  logic              privPrimary,
  input  logic              privSecondary,
  input  logic              privHome,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAbsAddr,
  output logic              rspOk,
  output logic              rspProtFault,
  output logic              rspWriteInvHint,
  output logic              rspModeErr,
  output logic              prefixAlignErr
);

  addrFlags_t   flags;
  ctrlStrobes_t strobes;

  low_guard_ctrl i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .reqValid       (reqValid),
    .reqIsStore     (reqIsStore),
    .protEnable     (protEnable),
    .xlateOn        (xlateOn),
    .spaceMode      (spaceMode),
    .privPrimary    (privPrimary),
    .privSecondary  (privSecondary),
    .privHome       (privHome),
    .prefixWrEn     (prefixWrEn),
    .flags          (flags),
    .strobes        (strobes),
    .prefixAlignErr (prefixAlignErr)
  );

  low_guard_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .WIN_BITS  (WIN_BITS),
    .NUM_WIN   (NUM_WIN)
  ) i_datapath (
    .clk             (clk),
    .rstN            (rstN),
    .reqAddr         (reqAddr),
    .prefixWrData    (prefixWrData),
    .strobes         (strobes),
    .flags           (flags),
    .rspValid        (rspValid),
    .rspAbsAddr      (rspAbsAddr),
    .rspOk           (rspOk),
    .rspProtFault    (rspProtFault),
    .rspWriteInvHint (rspWriteInvHint),
    .rspModeErr      (rspModeErr)
  );

endmodule

// File: tb/test_low_guard_relocator.sv
module test_low_guard_relocator;

  logic        clk = 1'b0;
  logic        rstN;
  logic        prefixWrEn;
  logic [63:0] prefixWrData;
  logic        reqValid;
  logic [63:0] reqAddr;
  logic        reqIsStore;
  logic        protEnable;
  logic        xlateOn;
  logic [1:0]  spaceMode;
  logic        privPrimary, privSecondary, privHome;
  logic        rspValid;
  logic [63:0] rspAbsAddr;
  logic        rspOk, rspProtFault, rspWriteInvHint, rspModeErr, prefixAlignErr;

  int checks = 0;
  int errors = 0;
  logic [63:0] benchPrefix = 64'd0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  low_guard_relocator i_low_guard_relocator (
    .clk(clk), .rstN(rstN), .prefixWrEn(prefixWrEn), .prefixWrData(prefixWrData),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqIsStore(reqIsStore),
    .protEnable(protEnable), .xlateOn(xlateOn), .spaceMode(spaceMode),
    .privPrimary(privPrimary), .privSecondary(privSecondary), .privHome(privHome),
    .rspValid(rspValid), .rspAbsAddr(rspAbsAddr), .rspOk(rspOk),
    .rspProtFault(rspProtFault), .rspWriteInvHint(rspWriteInvHint),
    .rspModeErr(rspModeErr), .prefixAlignErr(prefixAlignErr)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive one request, compute the expected response from the requirements, check it
  task automatic runReq(string tag, logic [63:0] addr, logic store, logic pEn,
                        logic xl, logic [1:0] mode, logic pP, logic pS, logic pH);
    logic badMode, priv, active, exact, page, fault, hint, ok;
    logic [63:0] abs;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqIsStore = store; protEnable = pEn;
    xlateOn = xl; spaceMode = mode;
    privPrimary = pP; privSecondary = pS; privHome = pH;
    badMode = xl && (mode == 2'd3);
    priv    = (mode == 2'd0) ? pP : (mode == 2'd1) ? pS : (mode == 2'd2) ? pH : 1'b0;
    active  = pEn && !(xl && priv) && !badMode;
    exact   = (addr <= 64'd511) || (addr >= 64'd4096 && addr <= 64'd4607);
    page    = addr < 64'd8192;
    fault   = active && store && exact;
    hint    = active && page;
    ok      = !badMode && !fault;
    if (!ok)                   abs = 64'd0;
    else if (addr < 64'h2000)  abs = addr + benchPrefix;
    else if (addr >= benchPrefix && addr < benchPrefix + 64'h2000) abs = addr - benchPrefix;
    else                       abs = addr;
    @(negedge clk);
    check(tag, "rspValid", 64'(rspValid), 64'd1);
    check(tag, "rspOk", 64'(rspOk), 64'(ok));
    check(tag, "rspProtFault", 64'(rspProtFault), 64'(fault));
    check(tag, "rspWriteInvHint", 64'(rspWriteInvHint), 64'(hint));
    check(tag, "rspModeErr", 64'(rspModeErr), 64'(badMode));
    check(tag, "rspAbsAddr", rspAbsAddr, abs);
    reqValid = 1'b0;
  endtask

  task automatic writePrefix(logic [63:0] value);
    logic aligned;
    aligned = (value[12:0] == 13'd0);
    @(negedge clk);
    prefixWrEn = 1'b1; prefixWrData = value;
    @(negedge clk);
    prefixWrEn = 1'b0;
    check("R10", "prefixAlignErr pulse", 64'(prefixAlignErr), 64'(!aligned));
    if (aligned) benchPrefix = value;
    @(negedge clk);
    check("R10", "prefixAlignErr clears", 64'(prefixAlignErr), 64'd0);
  endtask

  task automatic t_reset;
    check("R1", "rspValid", 64'(rspValid), 64'd0);
    check("R1", "flags", 64'({rspOk, rspProtFault, rspWriteInvHint, rspModeErr}), 64'd0);
    check("R1", "rspAbsAddr", rspAbsAddr, 64'd0);
    check("R1", "prefixAlignErr", 64'(prefixAlignErr), 64'd0);
    runReq("R1", 64'h1234, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_latency;
    runReq("R2", 64'h9000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R2", "rspValid drops", 64'(rspValid), 64'd0);
    check("R2", "flags idle", 64'({rspOk, rspProtFault, rspWriteInvHint, rspModeErr}), 64'd0);
  endtask

  task automatic t_windows;
    runReq("R3", 64'd0,    1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R3", 64'd511,  1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R3", 64'd512,  1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R3", 64'd4095, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R3", 64'd4096, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R3", 64'd4607, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R3", 64'd4608, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R3", 64'd100,  1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_hint;
    runReq("R4", 64'd3000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R4", 64'd8191, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R4", 64'd8192, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_disable;
    runReq("R5", 64'd16,   1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R5", 64'd4100, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_private;
    for (int m = 0; m < 3; m++) begin
      for (int b = 0; b < 3; b++) begin
        runReq("R6", 64'd8, 1'b1, 1'b1, 1'b1, 2'(m), b == 0, b == 1, b == 2);
      end
    end
    runReq("R6", 64'd8, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_modeErr;
    runReq("R7", 64'd8,     1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
    runReq("R7", 64'h50000, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
    runReq("R7", 64'd8,     1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_mapping;
    writePrefix(64'h0003_4000);
    runReq("R8", 64'd0,      1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R8", 64'h1ff8,   1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R9", 64'h3_4000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R9", 64'h3_5abc, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R9", 64'h3_6000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R9", 64'h3_3fff, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R9", 64'hdead_0000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_prefixLoad;
    writePrefix(64'h0007_1000);
    runReq("R10", 64'h20, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    writePrefix(64'h8000_0000_0000_0000);
    runReq("R10", 64'h20, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    runReq("R10", 64'h8000_0000_0000_1010, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    writePrefix(64'd0);
    runReq("R9", 64'h1010, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    rstN = 1'b0; prefixWrEn = 1'b0; prefixWrData = '0; reqValid = 1'b0; reqAddr = '0;
    reqIsStore = 1'b0; protEnable = 1'b0; xlateOn = 1'b0; spaceMode = 2'd0;
    privPrimary = 1'b0; privSecondary = 1'b0; privHome = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_windows();
    t_hint();
    t_disable();
    t_private();
    t_modeErr();
    t_mapping();
    t_prefixLoad();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule